// File: doc/BRIEF.md
# Threshold Fault Detector with Timestamp

This block watches an unsigned test statistic, one sample per clock, and compares each sample against a fixed detection threshold. The threshold is a parameter and defaults to 100. When a sample is strictly greater than the threshold, the block raises a fault flag and records the index of the cycle in which that sample was presented. The index comes from an internal free-running cycle counter that restarts at zero on reset.

The detector is sticky. The first exceedance after reset sets the flag and fixes the recorded time. Later samples cannot change either output, whatever their value, until the next reset. Both outputs are registered, so they change on the clock edge that samples the exceeding input. Producing the statistic, and deciding which source caused the fault, are done elsewhere.

Top module: `threshold_fault_monitor`

## Requirements
- R1: While `rst` is high, and on the first clock edge at which it is high, `fault_o` is driven to 0, `fault_time_o` to 0, and the internal cycle counter to 0.
- R2: The cycle counter is `TIME_W` bits wide. It advances by one on every clock edge with `rst` low and wraps modulo 2^`TIME_W`. The first sample after reset has index 0.
- R3: If `stat_i` is strictly greater than `THRESH` at a clock edge while no fault is held, `fault_o` is 1 after that edge.
- R4: A sample less than or equal to `THRESH`, including a sample exactly equal to it, does not set `fault_o`.
- R5: When the fault is captured, `fault_time_o` equals the counter index of the sample that caused it. After a counter wrap, this is the wrapped value.
- R6: Once `fault_o` is 1, it stays 1 until reset, even if `stat_i` later drops to or below the threshold.
- R7: Once a fault is held, `fault_time_o` does not change until reset, even if later samples exceed the threshold again.
- R8: `fault_time_o` reads 0 while no fault is held.
- R9: `stat_i` is compared as an unsigned number. A sample with its top bit set counts as large, not negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stat_i | input | DATA_W | Unsigned detection statistic, one sample per cycle |
| fault_o | output | 1 | Sticky fault flag (registered) |
| fault_time_o | output | TIME_W | Cycle index of the first exceedance, or 0 if no fault is held |

## Verification
The bench builds the block with `DATA_W`=10, `TIME_W`=8 and `THRESH`=100. With an 8-bit counter, a fault placed after 300 quiet cycles lands on the wrapped index 44 within a short run. The 10-bit input lets the bench drive 512 and 1023 to show that a set top bit counts as a large unsigned value. Directed runs cover:
- an exceedance at index 20,
- an input exactly at the threshold,
- an exceedance on the very first sample.

Randomized runs of varying length then mix below-threshold samples with later exceedances and re-exceedances.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  parameter int DEF_DATA_W = 16;
  parameter int DEF_TIME_W = 16;
  parameter int DEF_THRESH = 100;

  typedef enum logic {
    MON_WATCH   = 1'b0,
    MON_TRIPPED = 1'b1
  } mon_state_t;
endpackage

// File: rtl/tfm_time_base.sv
module tfm_time_base #(
  parameter int TIME_W = tfm_pkg::DEF_TIME_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TIME_W-1:0] now_o
);
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign now_o = cnt_q;
endmodule

// File: rtl/tfm_compare.sv
module tfm_compare #(
  parameter int DATA_W = tfm_pkg::DEF_DATA_W,
  parameter int THRESH = tfm_pkg::DEF_THRESH
) (
  input  logic [DATA_W-1:0] stat_i,
  output logic              above_o
);
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(THRESH);

  always_comb above_o = (stat_i > LIMIT);
endmodule

// File: rtl/tfm_capture.sv
module tfm_capture #(
  parameter int TIME_W = tfm_pkg::DEF_TIME_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              above_i,
  input  logic [TIME_W-1:0] now_i,
  output logic              fault_o,
  output logic [TIME_W-1:0] stamp_o
);
  import tfm_pkg::*;

  mon_state_t        st_q;
  logic [TIME_W-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= MON_WATCH;
      stamp_q <= '0;
    end else if (st_q == MON_WATCH && above_i) begin
      st_q    <= MON_TRIPPED;
      stamp_q <= now_i;
    end
  end

  assign fault_o = (st_q == MON_TRIPPED);
  assign stamp_o = stamp_q;
endmodule

// File: rtl/threshold_fault_monitor.sv
module threshold_fault_monitor #(
  parameter int DATA_W = tfm_pkg::DEF_DATA_W,
  parameter int TIME_W = tfm_pkg::DEF_TIME_W,
  parameter int THRESH = tfm_pkg::DEF_THRESH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] stat_i,
  output logic              fault_o,
  output logic [TIME_W-1:0] fault_time_o
);
  logic [TIME_W-1:0] now_w;
  logic              above_w;

  tfm_time_base #(.TIME_W(TIME_W)) u_time (
    .clk   (clk),
    .rst   (rst),
    .now_o (now_w)
  );

  tfm_compare #(.DATA_W(DATA_W), .THRESH(THRESH)) u_cmp (
    .stat_i  (stat_i),
    .above_o (above_w)
  );

  tfm_capture #(.TIME_W(TIME_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .above_i (above_w),
    .now_i   (now_w),
    .fault_o (fault_o),
    .stamp_o (fault_time_o)
  );
endmodule

// File: rtl/tfm_checker.sv
module tfm_checker #(
  parameter int DATA_W = tfm_pkg::DEF_DATA_W,
  parameter int TIME_W = tfm_pkg::DEF_TIME_W,
  parameter int THRESH = tfm_pkg::DEF_THRESH
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] stat_i,
  input logic              fault_o,
  input logic [TIME_W-1:0] fault_time_o
);
  logic [TIME_W-1:0] ref_cnt;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst) ref_cnt <= '0;
    else     ref_cnt <= ref_cnt + 1'b1;
  end

  assign hit = ({1'b0, stat_i} > (DATA_W+1)'(THRESH));

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (!fault_o && fault_time_o == '0));
  // R3
  exceed_sets_chk: assert property (@(posedge clk) disable iff (rst) (!fault_o && hit) |=> fault_o);
  // R4
  quiet_holds_chk: assert property (@(posedge clk) disable iff (rst) (!fault_o && !hit) |=> !fault_o);
  // R5
  stamp_value_chk: assert property (@(posedge clk) disable iff (rst) (!fault_o && hit) |=> (fault_time_o == $past(ref_cnt)));
  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst) fault_o |=> fault_o);
  // R7
  stamp_frozen_chk: assert property (@(posedge clk) disable iff (rst) fault_o |=> $stable(fault_time_o));
  // R8
  idle_time_zero_chk: assert property (@(posedge clk) disable iff (rst) !fault_o |-> (fault_time_o == '0));
endmodule

bind threshold_fault_monitor tfm_checker #(
  .DATA_W(DATA_W), .TIME_W(TIME_W), .THRESH(THRESH)
) u_tfm_chk (
  .clk          (clk),
  .rst          (rst),
  .stat_i       (stat_i),
  .fault_o      (fault_o),
  .fault_time_o (fault_time_o)
);

// File: tb/tb_threshold_fault_monitor.sv
`timescale 1ns/1ps
module tb_threshold_fault_monitor;
  localparam int DW = 10;
  localparam int TW = 8;
  localparam int TH = 100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] stat_i = '0;
  logic          fault_o;
  logic [TW-1:0] fault_time_o;

  int total = 0;
  int bad   = 0;

  logic          m_fault;
  logic [TW-1:0] m_time;
  logic [TW-1:0] m_cnt;

  always #10 clk = ~clk;

  threshold_fault_monitor #(.DATA_W(DW), .TIME_W(TW), .THRESH(TH)) dut (
    .clk(clk), .rst(rst), .stat_i(stat_i),
    .fault_o(fault_o), .fault_time_o(fault_time_o)
  );

  function automatic bit exceeds(input logic [DW-1:0] v);
    return int'(v) > TH;
  endfunction

  task automatic check_out(input string req);
    total++;
    if (fault_o !== m_fault || fault_time_o !== m_time) begin
      bad++;
      $display("FAIL %s: fault=%0d time=%0d expected fault=%0d time=%0d",
               req, fault_o, fault_time_o, m_fault, m_time);
    end
  endtask

  task automatic check_val(input string req, input logic [TW-1:0] exp_t, input logic exp_f);
    total++;
    if (fault_o !== exp_f || fault_time_o !== exp_t) begin
      bad++;
      $display("FAIL %s: fault=%0d time=%0d expected fault=%0d time=%0d",
               req, fault_o, fault_time_o, exp_f, exp_t);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    stat_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_fault = 1'b0;
    m_time = '0;
    m_cnt = '0;
    check_out("R1 reset state");
  endtask

  task automatic apply(input logic [DW-1:0] v, input string req);
    stat_i = v;
    @(posedge clk);
    if (!m_fault && exceeds(v)) begin
      m_fault = 1'b1;
      m_time = m_cnt;
    end
    m_cnt = m_cnt + 1'b1;
    @(negedge clk);
    check_out(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_fault = 1'b0; m_time = '0; m_cnt = '0;

    // R1, R3, R5: exceedance at index 20
    do_reset();
    for (int i = 0; i < 20; i++) apply(DW'($urandom_range(0, TH)), "R4 below");
    apply(DW'(200), "R3 exceed at 20");
    check_val("R5 stamp is 20", TW'(20), 1'b1);
    // R6, R7: drop below, then exceed again
    for (int i = 0; i < 10; i++) apply(DW'($urandom_range(0, TH)), "R6 sticky");
    apply(DW'(900), "R7 re-exceed ignored");
    check_val("R7 stamp still 20", TW'(20), 1'b1);

    // R4: equal to threshold, then one above
    do_reset();
    for (int i = 0; i < 5; i++) apply(DW'(TH), "R4 equal is no fault");
    check_val("R8 time zero no fault", '0, 1'b0);
    apply(DW'(TH + 1), "R3 one above");
    check_val("R5 stamp is 5", TW'(5), 1'b1);

    // R2/R5: first sample has index 0
    do_reset();
    apply(DW'(101), "R2 first index");
    check_val("R2 first index 0", '0, 1'b1);

    // R9: top bit set counts as large
    do_reset();
    apply(DW'(50), "R4 below");
    apply(DW'(512), "R9 unsigned 512");
    check_val("R9 stamp 1", TW'(1), 1'b1);
    do_reset();
    apply(DW'(1023), "R9 unsigned 1023");

    // R2: counter wrap, fault after 300 quiet samples -> 44
    do_reset();
    for (int i = 0; i < 300; i++) apply(DW'($urandom_range(0, TH)), "R8 quiet");
    apply(DW'($urandom_range(TH + 1, 1023)), "R2 exceed after wrap");
    check_val("R2 wrapped stamp 44", TW'(44), 1'b1);

    // random runs
    for (int r = 0; r < 25; r++) begin
      int len;
      do_reset();
      len = $urandom_range(0, 400);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 99) < 3) apply(DW'($urandom_range(TH + 1, 1023)), "R3 random");
        else apply(DW'($urandom_range(0, TH)), "R4 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule